// File: doc/BRIEF.md
# GPIO port with change interrupts

This block is one general-purpose I/O port of parametric width, controlled through a simple synchronous host register interface with an address, write data, a write strobe, a read strobe and combinational read data. The host writes an output register that drives the pins. It reads back the pin levels through a separate input register, which samples the pins rather than echoing the output latch, so a pin held low outside reads low even while its output bit is high. This allows quasi-bidirectional use.

Each pin has a 3-bit drive-mode code that is exported to the pad logic. It also has an inversion bit that flips the level it reports, and a select bit that routes an external PWM signal to the pin in place of its output bit. Pin inputs pass through a two-flop synchronizer. Any level change on a synchronized pin sets that pin's status bit. Reading the status register clears it. A single interrupt line is high while any status bit is set whose mask bit is clear.

The mask register comes out of reset as all ones, so every interrupt starts disabled. The host enables only the pins it wants to hear from.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset: the output, inversion and PWM-select registers are 0, the mask register is all ones, the status register is 0, every drive mode is pull-up (code 0), and `irq` is low. A pin level that is already present when reset ends sets no status bit.
- R2: A write to address 0 loads the output register. Every pin whose PWM-select bit is 0 drives that bit on `pin_out` from the cycle after the write. A read of address 0 returns the register.
- R3: A read of address 1 returns the synchronized pin levels XOR the inversion register (address 2). A pin change becomes visible there two clock edges after it appears on `pin_in`. The value does not depend on the output register.
- R4: The drive-mode code of pin i is written and read at address 8+i (low 3 bits) and appears on `pin_mode[3i+2:3i]`. The codes are 0 pull-up, 1 pull-down, 2 open-drain high, 3 open-drain low, 4 strong fast, 5 strong slow and 6 high impedance. A write of code 7 is ignored.
- R5: For each pin whose PWM-select bit (address 3) is 1, `pin_out` follows that pin's `pwm_in` bit instead of the output register.
- R6: Any change of a synchronized pin level, rising or falling, sets that pin's bit in the status register (address 5) on the third clock edge after the change on `pin_in`. This holds whatever the inversion and mask settings are.
- R7: A read of address 5 returns the status register and clears it on that clock edge. A change that is detected on the same edge as the read leaves its bit set.
- R8: `irq` is high exactly while some status bit is 1 and the matching mask bit (address 4, 1 = disabled) is 0. Writing the mask does not alter the status register.
- R9: The inversion, PWM-select and mask registers read back what was written. Writes to addresses 1, 5, 6 and 7 change nothing. Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (4) | Register address |
| reg_wdata | input | WIDTH (8) | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; a status read clears on this edge |
| reg_rdata | output | WIDTH (8) | Combinational read data for `reg_addr` |
| pin_in | input | WIDTH (8) | Asynchronous pin levels from the pads |
| pwm_in | input | WIDTH (8) | PWM signal offered to each pin |
| pin_out | output | WIDTH (8) | Level driven toward each pad |
| pin_mode | output | 3*WIDTH (24) | Per-pin drive-mode codes |
| irq | output | 1 | Active-high interrupt request |

## Verification
The output path is swept over all 256 output values, and the PWM-select register over all 256 values against two complementary PWM patterns. This shows that each pin picks its own source and does not depend on its neighbours. The input register is swept over all 256 pin patterns, each with a different inversion mask and an output value that disagrees with the pins, so an echo of the latch or a missing inversion shows up. Single-pin rising and falling changes check that status bits are placed correctly. A change timed to land on the read edge tells apart a clear that drops the event from one that keeps it. A full sweep of the mask against a fixed status pattern checks the interrupt equation bit by bit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      DM_PULL_UP     = 3'd0,
      DM_PULL_DOWN   = 3'd1,
      DM_OD_HIGH     = 3'd2,
      DM_OD_LOW      = 3'd3,
      DM_STRONG_FAST = 3'd4,
      DM_STRONG_SLOW = 3'd5,
      DM_HIGH_Z      = 3'd6
   } drive_mode_e;

   localparam int ADR_OUT       = 0;
   localparam int ADR_IN        = 1;
   localparam int ADR_INV       = 2;
   localparam int ADR_PWM       = 3;
   localparam int ADR_MASK      = 4;
   localparam int ADR_STAT      = 5;
   localparam int ADR_MODE_BASE = 8;

   function automatic logic mode_legal(input logic [MODE_W-1:0] code);
      return code <= DM_HIGH_Z;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
   parameter int WIDTH = 8,
   parameter int PRIME = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic             clr,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] chg,
   output logic [WIDTH-1:0] status,
   output logic             irq
);
   generate
      if (PRIME < 2) begin : g_bad_prime
         $error("gpio_irq_status: PRIME must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] prev;
   logic [PRIME-1:0] warm;
   logic             ready;

   assign ready = warm[PRIME-1];
   assign chg   = ready ? (level ^ prev) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm   <= '0;
         prev   <= '0;
         status <= '0;
      end else begin
         warm   <= {warm[PRIME-2:0], 1'b1};
         prev   <= level;
         status <= (clr ? '0 : status) | chg;
      end
   end

   assign irq = |(status & ~mask);
endmodule

// File: rtl/gpio_mode_bank.sv
module gpio_mode_bank
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [WIDTH-1:0]        we,
   input  logic [MODE_W-1:0]       wcode,
   output logic [WIDTH*MODE_W-1:0] modes
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         drive_mode_e mode_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          mode_q <= DM_PULL_UP;
            else if (we[i] && mode_legal(wcode)) mode_q <= drive_mode_e'(wcode);
         end
         assign modes[i*MODE_W +: MODE_W] = mode_q;
      end
   endgenerate
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic [WIDTH-1:0]        reg_wdata,
   input  logic                    reg_wr,
   input  logic                    reg_rd,
   output logic [WIDTH-1:0]        reg_rdata,
   input  logic [WIDTH-1:0]        pin_in,
   input  logic [WIDTH-1:0]        pwm_in,
   output logic [WIDTH-1:0]        pin_out,
   output logic [WIDTH*MODE_W-1:0] pin_mode,
   output logic                    irq
);
   localparam int PRIME = SYNC_STAGES + 1;
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (WIDTH < MODE_W) begin : g_bad_width
         $error("gpio_port_irq: WIDTH must hold a drive-mode code");
      end
      if (ADDR_SPAN < ADR_MODE_BASE + WIDTH) begin : g_bad_addr
         $error("gpio_port_irq: ADDR_W too small for the mode registers");
      end
   endgenerate

   logic [WIDTH-1:0] out_q, inv_q, pwm_q, mask_q;
   logic [WIDTH-1:0] sync_lvl, chg, status_q;
   logic [WIDTH-1:0] mode_we;
   logic             stat_clr;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
      return a == ADDR_W'(target);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         inv_q  <= '0;
         pwm_q  <= '0;
         mask_q <= '1;
      end else if (reg_wr) begin
         if (hit(reg_addr, ADR_OUT))  out_q  <= reg_wdata;
         if (hit(reg_addr, ADR_INV))  inv_q  <= reg_wdata;
         if (hit(reg_addr, ADR_PWM))  pwm_q  <= reg_wdata;
         if (hit(reg_addr, ADR_MASK)) mask_q <= reg_wdata;
      end
   end

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl)
   );

   assign stat_clr = reg_rd && hit(reg_addr, ADR_STAT);

   gpio_irq_status #(.WIDTH(WIDTH), .PRIME(PRIME)) u_stat (
      .clk(clk), .rst_n(rst_n), .level(sync_lvl), .clr(stat_clr),
      .mask(mask_q), .chg(chg), .status(status_q), .irq(irq)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_mode_we
         assign mode_we[i] = reg_wr && hit(reg_addr, ADR_MODE_BASE + i);
      end
   endgenerate

   gpio_mode_bank #(.WIDTH(WIDTH)) u_modes (
      .clk(clk), .rst_n(rst_n), .we(mode_we),
      .wcode(reg_wdata[MODE_W-1:0]), .modes(pin_mode)
   );

   assign pin_out = (pwm_q & pwm_in) | (~pwm_q & out_q);

   always_comb begin
      reg_rdata = '0;
      case (int'(reg_addr))
         ADR_OUT:  reg_rdata = out_q;
         ADR_IN:   reg_rdata = sync_lvl ^ inv_q;
         ADR_INV:  reg_rdata = inv_q;
         ADR_PWM:  reg_rdata = pwm_q;
         ADR_MASK: reg_rdata = mask_q;
         ADR_STAT: reg_rdata = status_q;
         default: begin
            for (int i = 0; i < WIDTH; i++)
               if (hit(reg_addr, ADR_MODE_BASE + i))
                  reg_rdata = WIDTH'(pin_mode[i*MODE_W +: MODE_W]);
         end
      endcase
   end
endmodule

// File: rtl/gpio_port_irq_chk.sv
module gpio_port_irq_chk
   import gpio_port_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int ADDR_W = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       reg_addr,
   input logic [WIDTH-1:0]        reg_wdata,
   input logic                    reg_wr,
   input logic                    reg_rd,
   input logic [WIDTH-1:0]        pwm_in,
   input logic [WIDTH-1:0]        pin_out,
   input logic [WIDTH*MODE_W-1:0] pin_mode,
   input logic                    irq,
   input logic [WIDTH-1:0]        chg,
   input logic [WIDTH-1:0]        status_q,
   input logic [WIDTH-1:0]        mask_q,
   input logic [WIDTH-1:0]        pwm_q
);
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(ADR_STAT) && chg == '0) |=> status_q == '0);

   a_r6_change_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (chg != '0) |=> ((status_q & $past(chg)) == $past(chg)));

   a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '1) |-> !irq);

   a_r2_out_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(ADR_OUT) && pwm_q == '0) |=> pin_out == $past(reg_wdata));

   a_r5_pwm_route: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_q == '1) |-> pin_out == pwm_in);

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_mode
         a_r4_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
            pin_mode[i*MODE_W +: MODE_W] != 3'd7);
      end
   endgenerate
endmodule

bind gpio_port_irq gpio_port_irq_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .reg_wr(reg_wr), .reg_rd(reg_rd), .pwm_in(pwm_in), .pin_out(pin_out),
   .pin_mode(pin_mode), .irq(irq), .chg(chg), .status_q(status_q),
   .mask_q(mask_q), .pwm_q(pwm_q)
);

// File: tb/gpio_port_irq_tb.sv
`timescale 1ns/1ps
module gpio_port_irq_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [3:0]  reg_addr = 0;
   logic [7:0]  reg_wdata = 0;
   logic        reg_wr = 0, reg_rd = 0;
   logic [7:0]  reg_rdata;
   logic [7:0]  pin_in = 8'h3C, pwm_in = 0;
   logic [7:0]  pin_out;
   logic [23:0] pin_mode;
   logic        irq;
   int n_chk = 0, n_err = 0;

   always #2.5 clk = ~clk;

   gpio_port_irq u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pwm_in(pwm_in), .pin_out(pin_out), .pin_mode(pin_mode), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a; reg_rd = 1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
      logic [7:0] v;
      rd(a, v);
      chk(tag, 32'(v), 32'(exp));
   endtask

   task automatic set_pins(input logic [7:0] v);
      @(negedge clk);
      pin_in = v;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] v, inv, pat, last, exp_mode [8];
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (6) @(negedge clk);
      // R1 reset state
      chk("R1 pin_out", 32'(pin_out), 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 pin_mode", 32'(pin_mode), 0);
      rd_chk(0, 8'h00, "R1 out");
      rd_chk(2, 8'h00, "R1 inv");
      rd_chk(3, 8'h00, "R1 pwm");
      rd_chk(4, 8'hFF, "R1 mask");
      rd_chk(5, 8'h00, "R1 status no change at reset");
      rd_chk(1, 8'h3C, "R1 input after reset");
      for (int i = 0; i < 8; i++) begin
         rd_chk(4'(8 + i), 8'h00, "R1 mode pull-up");
         exp_mode[i] = 0;
      end

      // R2 output register sweep
      for (int k = 0; k < 256; k++) begin
         wr(0, 8'(k));
         chk("R2 pin_out", 32'(pin_out), 32'(k));
         if (k % 32 == 5) rd_chk(0, 8'(k), "R2 readback");
      end

      // R3 input register sweep with inversion, output disagreeing
      for (int k = 0; k < 256; k++) begin
         inv = 8'(k * 7 + 3);
         wr(2, inv);
         wr(0, ~8'(k));
         set_pins(8'(k));
         repeat (2) @(negedge clk);
         rd_chk(1, 8'(k) ^ inv, "R3 input");
      end

      // R4 drive modes
      for (int i = 0; i < 8; i++) begin
         for (int c = 0; c < 8; c++) begin
            wr(4'(8 + i), 8'(c) | 8'hF0);
            if (c != 7) exp_mode[i] = 8'(c);
            chk("R4 pin_mode field", 32'(pin_mode[i*3 +: 3]), 32'(exp_mode[i]));
         end
         rd_chk(4'(8 + i), exp_mode[i], "R4 readback (code 7 ignored)");
      end

      // R5 PWM select sweep
      wr(0, 8'h3C);
      for (int s = 0; s < 256; s++) begin
         wr(3, 8'(s));
         @(negedge clk); pwm_in = 8'h96; #1;
         chk("R5 pin_out a", 32'(pin_out), 32'((8'h96 & 8'(s)) | (8'h3C & ~8'(s))));
         @(negedge clk); pwm_in = 8'h69; #1;
         chk("R5 pin_out b", 32'(pin_out), 32'((8'h69 & 8'(s)) | (8'h3C & ~8'(s))));
      end
      rd_chk(3, 8'hFF, "R9 pwm readback");
      wr(3, 8'h00);

      // R6 single-pin changes, both directions, inversion set
      wr(2, 8'hFF);
      wr(4, 8'h00);
      repeat (4) @(negedge clk);
      rd(5, v);
      rd_chk(5, 8'h00, "R7 status cleared");
      last = pin_in;
      for (int i = 0; i < 8; i++) begin
         for (int dir = 0; dir < 2; dir++) begin
            last = last ^ (8'h01 << i);
            set_pins(last);
            @(negedge clk); @(negedge clk);
            chk("R6 not yet set before third edge", 32'(irq), 0);
            @(negedge clk);
            chk("R8 irq on change", 32'(irq), 1);
            rd_chk(5, 8'h01 << i, "R6 status bit");
            chk("R7 irq after read", 32'(irq), 0);
         end
      end

      // R7 change detected on the read edge is kept
      last = last ^ 8'h10;
      set_pins(last);
      @(negedge clk);
      rd(5, v);
      chk("R7 read on change edge returns old", 32'(v), 0);
      rd_chk(5, 8'h10, "R7 change kept across read");
      rd_chk(5, 8'h00, "R7 second read clears");

      // R8 mask sweep against fixed status pattern
      pat = 8'hA5;
      last = last ^ pat;
      set_pins(last);
      repeat (4) @(negedge clk);
      for (int m = 0; m < 256; m++) begin
         wr(4, 8'(m));
         chk("R8 irq vs mask", 32'(irq), 32'(|(pat & ~8'(m))));
      end
      rd_chk(4, 8'hFF, "R9 mask readback");
      rd_chk(5, pat, "R8 status kept by mask writes");

      // R9 ignored writes and unused addresses
      wr(2, 8'h00);
      wr(1, 8'h77);
      rd_chk(1, last, "R9 input write ignored");
      wr(5, 8'hFF);
      rd_chk(5, 8'h00, "R9 status write ignored");
      wr(6, 8'hFF);
      wr(7, 8'hFF);
      rd_chk(6, 8'h00, "R9 addr 6 reads 0");
      rd_chk(7, 8'h00, "R9 addr 7 reads 0");
      rd_chk(2, 8'h00, "R9 inv readback");
      chk("R9 pin_out unchanged", 32'(pin_out), 32'h3C);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule